// File: doc/BRIEF.md
# Affine Binary-Field Point Add/Double Unit

This block performs one group operation on the binary elliptic curve y^2 + xy = x^3 + a·x^2 + b over GF(2^M). Points use affine coordinates and field elements use polynomial basis. An opcode selects one of two operations. The first adds two distinct points (x1,y1) and (x2,y2). The second doubles (x1,y1). The result (x3,y3) is presented together with a completion pulse.

All field arithmetic is reduced modulo the irreducible polynomial given by the parameter `POLY`. An example is x^163 + x^7 + x^6 + x^3 + 1 for M = 163. The default is M = 8 with x^8 + x^4 + x^3 + x + 1.

A small state sequencer routes operands through shared units:
- one division unit based on the binary extended Euclidean algorithm, which yields the slope directly without a separate inversion;
- one bit-serial multiplier;
- one combinational squarer;
- XOR adders.

A scalar-multiplication controller issues one operation per `start`. It then waits for `done` before reading the result.

Top module: `ecc_affine_pt_unit`

## Requirements
- R1: Addition (`op_dbl` = 0) forms slope s = (y1 ^ y2) / (x1 ^ x2). It then gives x3 = s^2 ^ s ^ x1 ^ x2 ^ a, with all products reduced modulo `POLY`.
- R2: Addition gives y3 = s·(x1 ^ x3) ^ x3 ^ y1.
- R3: Doubling (`op_dbl` = 1) with x1 ≠ 0 forms s = x1 ^ (y1 / x1). It then gives x3 = s^2 ^ s ^ a and y3 = x1^2 ^ s·x3 ^ x3.
- R4: Doubling with x1 = 0 gives x3 = 0 and y3 = 0. `done` is high right after the same clock edge that samples `start`, and no division is run.
- R5: After reset `done`, `x3` and `y3` are 0. `x3` and `y3` change only in a cycle where `done` is high, and hold their values until the next completion. `done` is high for exactly one cycle per accepted operation.
- R6: `start` is accepted only when the unit is idle. A `start` raised while an operation is in progress is ignored, and the operand and opcode values presented with it have no effect on the result.
- R7: Every operation other than R4 asserts `done` at most 3·M+6 clock edges after the edge that samples `start`. The divider finishes within 2·M cycles of its own start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| op_dbl | input | 1 | 1 = double (x1,y1), 0 = add (x1,y1)+(x2,y2) |
| a_coef | input | M | Curve coefficient a |
| x1 | input | M | First point, x coordinate |
| y1 | input | M | First point, y coordinate |
| x2 | input | M | Second point, x coordinate (addition only) |
| y2 | input | M | Second point, y coordinate (addition only) |
| x3 | output | M | Result x coordinate |
| y3 | output | M | Result y coordinate |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupted slope register or a wrong divider step affects both output coordinates at the next `done`, because the slope feeds x3 and, through x3, y3. A fault in the multiplier or in the squarer's operand selection shows only in y3 at that same pulse. A sequencer that loses track of completion pulses shows up as a missing `done` beyond the 3·M+6 edge bound. A sequencer that re-latches operands while busy shows up as a result matching the injected second operand set instead of the first. The zero-x doubling case and the output hold between operations are observable within one cycle of their stimulus.

// File: rtl/ecc_pt_pkg.sv
package ecc_pt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIVGO,
      ST_DIVW,
      ST_XCALC,
      ST_MULGO,
      ST_MULW,
      ST_YCALC
   } seq_st_t;

endpackage

// File: rtl/gf_sqr_comb.sv
module gf_sqr_comb #(
   parameter int           M    = 8,
   parameter logic [M:0]   POLY = 9'h11B
) (
   input  logic [M-1:0] a,
   output logic [M-1:0] r
);
   localparam int WW = 2*M-1;
   localparam logic [WW-1:0] PEXT = {{(M-2){1'b0}}, POLY};

   logic [WW-1:0] spread;

   // interleave zeros between operand bits: squaring in GF(2) is bit spreading
   for (genvar g = 0; g < M; g++) begin : g_spread
      assign spread[2*g] = a[g];
      if (g < M-1) begin : g_gap
         assign spread[2*g+1] = 1'b0;
      end
   end

   always_comb begin
      logic [WW-1:0] w;
      w = spread;
      for (int i = WW-1; i >= M; i--) begin
         if (w[i]) w = w ^ (PEXT << (i - M));
      end
      r = w[M-1:0];
   end
endmodule

// File: rtl/gf_mul_serial.sv
module gf_mul_serial #(
   parameter int           M    = 8,
   parameter logic [M:0]   POLY = 9'h11B
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [M-1:0] a,
   input  logic [M-1:0] b,
   output logic [M-1:0] p,
   output logic         done
);
   localparam int CW = $clog2(M+1);

   logic [M-1:0]  acc, ar, br;
   logic [CW-1:0] cnt;
   logic          busy;

   function automatic logic [M-1:0] mulx(input logic [M-1:0] v);
      return {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY[M-1:0] : '0);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         ar   <= '0;
         br   <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            acc  <= '0;
            ar   <= a;
            br   <= b;
            cnt  <= CW'(M);
            busy <= 1'b1;
         end else if (busy) begin
            // MSB first: shift-and-reduce, then conditionally add multiplicand
            acc <= mulx(acc) ^ (br[M-1] ? ar : '0);
            br  <= br << 1;
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign p = acc;

   AST_MUL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt > CW'(M)) |-> 1'b0); // R7
endmodule

// File: rtl/gf_div_euclid.sv
module gf_div_euclid #(
   parameter int           M    = 8,
   parameter logic [M:0]   POLY = 9'h11B
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [M-1:0] num,
   input  logic [M-1:0] den,
   output logic [M-1:0] quo,
   output logic         done
);
   localparam int IW = $clog2(2*M+2);

   logic [M:0]    ra, rb;
   logic [M-1:0]  ru, rv;
   logic          busy;
   logic [IW-1:0] iters;

   // divide by x modulo POLY
   function automatic logic [M-1:0] halve(input logic [M-1:0] u);
      logic [M:0] h;
      h = {1'b0, u} ^ (u[0] ? POLY : '0);
      return h[M:1];
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ra    <= '0;
         rb    <= '0;
         ru    <= '0;
         rv    <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
         iters <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            ra    <= {1'b0, den};
            rb    <= POLY;
            ru    <= num;
            rv    <= '0;
            busy  <= 1'b1;
            iters <= '0;
         end else if (busy) begin
            if (ra == rb || ra == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               iters <= iters + 1'b1;
               if (!ra[0]) begin
                  ra <= ra >> 1;
                  ru <= halve(ru);
               end else if (!rb[0]) begin
                  rb <= rb >> 1;
                  rv <= halve(rv);
               end else if (ra > rb) begin
                  ra <= (ra ^ rb) >> 1;
                  ru <= halve(ru ^ rv);
               end else begin
                  rb <= (ra ^ rb) >> 1;
                  rv <= halve(ru ^ rv);
               end
            end
         end
      end
   end

   assign quo = (ra == '0) ? '0 : ru;

   AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (iters < IW'(2*M))); // R7
   AST_DIV_GCD: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((ra == rb && ra == (M+1)'(1)) || ra == '0)); // R1
endmodule

// File: rtl/ecc_affine_pt_unit.sv
module ecc_affine_pt_unit
   import ecc_pt_pkg::*;
#(
   parameter int           M    = 8,
   parameter logic [M:0]   POLY = 9'h11B
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         op_dbl,
   input  logic [M-1:0] a_coef,
   input  logic [M-1:0] x1,
   input  logic [M-1:0] y1,
   input  logic [M-1:0] x2,
   input  logic [M-1:0] y2,
   output logic [M-1:0] x3,
   output logic [M-1:0] y3,
   output logic         done
);
   if (M < 4) begin : g_bad_m
      $error("field degree M must be at least 4");
   end
   if (POLY[M] != 1'b1 || POLY[0] != 1'b1) begin : g_bad_poly
      $error("POLY must have degree M and a nonzero constant term");
   end

   seq_st_t      st;
   logic         dbl_r;
   logic [M-1:0] a_r, x1_r, y1_r, x2_r, y2_r;
   logic [M-1:0] lam, x3_w;

   logic [M-1:0] div_num, div_den, div_q;
   logic         div_start, div_done;
   logic [M-1:0] mul_b, mul_p;
   logic         mul_start, mul_done;
   logic [M-1:0] sq_in, sq_out;

   assign div_num   = dbl_r ? y1_r : (y1_r ^ y2_r);
   assign div_den   = dbl_r ? x1_r : (x1_r ^ x2_r);
   assign div_start = (st == ST_DIVGO);
   assign mul_b     = dbl_r ? x3_w : (x1_r ^ x3_w);
   assign mul_start = (st == ST_MULGO);
   assign sq_in     = (st == ST_YCALC) ? x1_r : lam;

   gf_div_euclid #(.M(M), .POLY(POLY)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start),
      .num(div_num), .den(div_den), .quo(div_q), .done(div_done)
   );

   gf_mul_serial #(.M(M), .POLY(POLY)) u_mul (
      .clk(clk), .rst_n(rst_n), .start(mul_start),
      .a(lam), .b(mul_b), .p(mul_p), .done(mul_done)
   );

   gf_sqr_comb #(.M(M), .POLY(POLY)) u_sqr (
      .a(sq_in), .r(sq_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         dbl_r <= 1'b0;
         a_r   <= '0;
         x1_r  <= '0;
         y1_r  <= '0;
         x2_r  <= '0;
         y2_r  <= '0;
         lam   <= '0;
         x3_w  <= '0;
         x3    <= '0;
         y3    <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               dbl_r <= op_dbl;
               a_r   <= a_coef;
               x1_r  <= x1;
               y1_r  <= y1;
               x2_r  <= x2;
               y2_r  <= y2;
               if (op_dbl && x1 == '0) begin
                  x3   <= '0;
                  y3   <= '0;
                  done <= 1'b1;
               end else begin
                  st <= ST_DIVGO;
               end
            end
            ST_DIVGO: st <= ST_DIVW;
            ST_DIVW: if (div_done) begin
               lam <= dbl_r ? (x1_r ^ div_q) : div_q;
               st  <= ST_XCALC;
            end
            ST_XCALC: begin
               x3_w <= sq_out ^ lam ^ a_r ^ (dbl_r ? '0 : (x1_r ^ x2_r));
               st   <= ST_MULGO;
            end
            ST_MULGO: st <= ST_MULW;
            ST_MULW: if (mul_done) st <= ST_YCALC;
            ST_YCALC: begin
               x3   <= x3_w;
               y3   <= dbl_r ? (sq_out ^ mul_p ^ x3_w) : (mul_p ^ x3_w ^ y1_r);
               done <= 1'b1;
               st   <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_ZERO_DBL: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && start && op_dbl && x1 == '0) |=> (done && x3 == '0 && y3 == '0)); // R4
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(x3) && $stable(y3))); // R5
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE) |=> ($stable(x1_r) && $stable(y1_r) && $stable(dbl_r))); // R6
   AST_DIV_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      div_done |-> (st == ST_DIVW)); // R7
   AST_MUL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      mul_done |-> (st == ST_MULW)); // R2
endmodule

// File: tb/ecc_affine_pt_unit_bench.sv
module ecc_affine_pt_unit_bench;
   localparam int         BM    = 8;
   localparam logic [BM:0] BPOLY = 9'h11B;
   localparam int         LAT   = 3*BM + 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          op_dbl = 1'b0;
   logic [BM-1:0] a_coef = '0, x1 = '0, y1 = '0, x2 = '0, y2 = '0;
   logic [BM-1:0] x3, y3;
   logic          done;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit over   = 0;

   always #2 clk = ~clk;

   ecc_affine_pt_unit #(.M(BM), .POLY(BPOLY)) u_ecc_affine_pt_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .op_dbl(op_dbl),
      .a_coef(a_coef), .x1(x1), .y1(y1), .x2(x2), .y2(y2),
      .x3(x3), .y3(y3), .done(done)
   );

   // independent field model: LSB-first multiply, inverse by Fermat power
   function automatic logic [BM-1:0] f_mul(input logic [BM-1:0] a, input logic [BM-1:0] b);
      logic [BM-1:0] r, t;
      r = '0;
      t = a;
      for (int i = 0; i < BM; i++) begin
         if (b[i]) r = r ^ t;
         t = {t[BM-2:0], 1'b0} ^ (t[BM-1] ? BPOLY[BM-1:0] : '0);
      end
      return r;
   endfunction

   function automatic logic [BM-1:0] f_div(input logic [BM-1:0] y, input logic [BM-1:0] x);
      logic [BM-1:0] t, inv;
      t   = x;
      inv = 1;
      for (int i = 1; i < BM; i++) begin
         t   = f_mul(t, t);
         inv = f_mul(inv, t);
      end
      return f_mul(y, inv);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   task automatic run_op(input bit dbl_i, input logic [BM-1:0] a_i, input logic [BM-1:0] x1_i,
                         input logic [BM-1:0] y1_i, input logic [BM-1:0] x2_i,
                         input logic [BM-1:0] y2_i, input bit inject);
      logic [BM-1:0] s, ex3, ey3;
      int n;
      if (dbl_i) begin
         if (x1_i == '0) begin
            ex3 = '0;
            ey3 = '0;
         end else begin
            s   = x1_i ^ f_div(y1_i, x1_i);
            ex3 = f_mul(s, s) ^ s ^ a_i;
            ey3 = f_mul(x1_i, x1_i) ^ f_mul(s, ex3) ^ ex3;
         end
      end else begin
         s   = f_div(y1_i ^ y2_i, x1_i ^ x2_i);
         ex3 = f_mul(s, s) ^ s ^ x1_i ^ x2_i ^ a_i;
         ey3 = f_mul(s, x1_i ^ ex3) ^ ex3 ^ y1_i;
      end
      @(negedge clk);
      op_dbl = dbl_i; a_coef = a_i; x1 = x1_i; y1 = y1_i; x2 = x2_i; y2 = y2_i;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done && n <= LAT + 4) begin
         if (inject && n == 2) begin
            // R6: second start with different operands while busy
            op_dbl = ~dbl_i; x1 = ~x1_i; y1 = y1_i + 8'd7; x2 = ~x2_i; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(posedge clk);
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      if (dbl_i && x1_i == '0)
         chk(n == 0, "R4 zero-x latency", n, 0);
      else
         chk(n >= 1 && n <= LAT, "R7 latency", n, LAT);
      if (inject) begin
         chk(x3 == ex3, "R6 x3", x3, ex3);
         chk(y3 == ey3, "R6 y3", y3, ey3);
      end else if (dbl_i) begin
         chk(x3 == ex3, dbl_i && x1_i == '0 ? "R4 x3" : "R3 x3", x3, ex3);
         chk(y3 == ey3, dbl_i && x1_i == '0 ? "R4 y3" : "R3 y3", y3, ey3);
      end else begin
         chk(x3 == ex3, "R1 x3", x3, ex3);
         chk(y3 == ey3, "R2 y3", y3, ey3);
      end
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !over) begin
         over = 1;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
         summary();
      end
   end

   initial begin
      logic [BM-1:0] hx, hy, ra, rx1, ry1, rx2, ry2;
      void'($urandom(32'd4141));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R5 reset done", done, 0);
      chk(x3 == '0, "R5 reset x3", x3, 0);
      chk(y3 == '0, "R5 reset y3", y3, 0);
      rst_n = 1'b1;

      // directed corners
      run_op(0, 8'h00, 8'h00, 8'h35, 8'h9A, 8'h12, 0);  // x1 = 0 in addition
      run_op(0, 8'hFF, 8'h4C, 8'h77, 8'h1D, 8'h77, 0);  // y1 = y2, slope 0
      run_op(0, 8'h01, 8'h80, 8'h01, 8'h81, 8'hFE, 0);  // x1^x2 = 1
      run_op(1, 8'h03, 8'h5B, 8'h00, 8'h00, 8'h00, 0);  // y1 = 0, slope = x1
      run_op(1, 8'h03, 8'h01, 8'hC4, 8'h00, 8'h00, 0);  // x1 = 1
      run_op(1, 8'h2A, 8'h00, 8'h66, 8'h00, 8'h00, 0);  // R4 zero x
      run_op(1, 8'h2A, 8'h00, 8'h11, 8'h00, 8'h00, 0);  // R4 back to back
      run_op(0, 8'h09, 8'hA3, 8'h5E, 8'h3C, 8'hD1, 1);  // R6 injected start
      run_op(1, 8'h09, 8'hA3, 8'h5E, 8'h00, 8'h00, 1);  // R6 injected start

      // R5: outputs hold and done stays low while idle with toggling inputs
      hx = x3;
      hy = y3;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         x1 = 8'($urandom); y1 = 8'($urandom); op_dbl = k[0];
         @(posedge clk);
         @(negedge clk);
         chk(done == 1'b0, "R5 idle done", done, 0);
         chk(x3 == hx && y3 == hy, "R5 hold", {x3, y3}, {hx, hy});
      end

      // constrained random mix
      for (int v = 0; v < 240; v++) begin
         ra  = 8'($urandom);
         rx1 = ($urandom % 9 == 0) ? 8'h00 : 8'($urandom);
         ry1 = 8'($urandom);
         rx2 = 8'($urandom);
         ry2 = 8'($urandom);
         if (v % 2 == 0) begin
            if (rx2 == rx1) rx2 = rx1 ^ 8'h01;
            run_op(0, ra, rx1, ry1, rx2, ry2, v % 37 == 5);
         end else begin
            run_op(1, ra, rx1, ry1, rx2, ry2, v % 41 == 7);
         end
      end

      over = 1;
      summary();
   end
endmodule